// File: doc/BRIEF.md
# Two-Stage Key-Locked Watchdog Timer

This block is a memory-mapped watchdog that sits on a plain 32-bit register bus. The bus has separate read and write strobes, a 12-bit byte address, and write and read data. A down-counter is reloaded from a programmable reload value. When it reaches zero it expires, reloads itself and keeps counting. The first expiry raises an interrupt. If software has not acknowledged that interrupt by the next expiry, and reset generation is enabled, the block drives a system reset request.

Every register write is dropped unless the block has first been opened by writing a fixed key word to the lock register. Any other value written there closes it again. Software services the watchdog by writing the clear register, which acknowledges the interrupt and restarts the count. The live count can be read at any time, so software can work out how much time is left.

A parameter selects how the reset request behaves. It can stay held until the block itself is reset, or it can be a one-cycle pulse for each second-stage expiry. The interrupt output is a level.

Top module: `wdog_two_stage`

## Requirements
- R1: Out of reset the block is locked, and the lock register (0xC00) reads 1. Writing 0x1ACCE551 there unlocks it, so it reads 0. Writing any other value locks it again, so it reads 1. Writes to the lock register are accepted whether the block is locked or not.
- R2: While locked, writes to every other register are dropped: reload (0x000), control (0x008) and clear (0x00C). Reads are always served.
- R3: In the control register (0x008), bit 0 is the run bit and bit 1 enables reset generation. Bits 31:2 read as zero.
- R4: Writing the control register changes the run bit from 0 to 1 at bus edge k. That write loads the counter from the reload value N. The counter then decrements once per clock. When it is zero it expires and reloads N. The first expiry sets the interrupt after edge k+N+1, and the period is N+1 cycles.
- R5: The counter expires again while the interrupt is pending and reset generation is enabled. The reset request is then asserted after edge k+2N+2. With reset generation disabled it is never asserted.
- R6: Writing the clear register (0x00C) with bit 0 = 1 clears the pending interrupt and reloads the counter from N. This takes priority over an expiry on the same edge. Writing it with bit 0 = 0 has no effect.
- R7: The status register (0x014) reads 1 while the interrupt is pending and 0 otherwise.
- R8: A read strobe sampled at an edge returns the register contents from just before that edge on rdata after the edge. The count register (0x004) reads the live counter value.
- R9: With the run bit at 0 the counter is frozen and no expiry happens. A pending interrupt is kept, and no reset request is raised.
- R10: With RST_STICKY = 1 the reset request stays high until rst_n. With RST_STICKY = 0 it is high for exactly one cycle per second-stage expiry.
- R11: After reset the interrupt and reset request are low, the control register reads 0, and status reads 0. The reload and count registers both read LOAD_INIT (all ones by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Interrupt level, high while pending |
| sys_rst | output | 1 | System reset request |

## Verification
A write takes effect at the edge that samples it. Read data appears after the edge that samples the strobe and shows the value from before that edge. The first interrupt is due exactly N+1 edges after the enabling write, and the reset request is due 2N+2 edges after it. The bench drives every transfer from a falling edge and samples one falling edge after each relevant rising edge. It counts falling edges from the enabling write until each output rises, and compares that count with the arithmetic value. It does this for reload values 0 to 5, with reset generation both on and off, on a held-request instance and a pulsed-request instance side by side. Reads of the live count are issued back to back, so each read must return exactly one less than the one before.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned BUS_W  = 32;
   localparam int unsigned ADDR_W = 12;

   localparam logic [ADDR_W-1:0] A_RELOAD = 12'h000;
   localparam logic [ADDR_W-1:0] A_COUNT  = 12'h004;
   localparam logic [ADDR_W-1:0] A_CTRL   = 12'h008;
   localparam logic [ADDR_W-1:0] A_CLEAR  = 12'h00C;
   localparam logic [ADDR_W-1:0] A_STAT   = 12'h014;
   localparam logic [ADDR_W-1:0] A_LOCK   = 12'hC00;

   localparam int unsigned CTRL_RUN_BIT = 0;
   localparam int unsigned CTRL_RST_BIT = 1;

   typedef struct packed {
      logic rst_en;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
   import wdog_pkg::*;
#(
   parameter int unsigned          CNT_W     = 32,
   parameter logic [BUS_W-1:0]     KEY       = 32'h1ACC_E551,
   parameter logic [CNT_W-1:0]     LOAD_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              irq_pend,
   output logic [BUS_W-1:0]  rdata,
   output logic              locked,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  reload_val,
   output logic              reload_req,
   output logic              clr_req
);
   logic wr_open;
   logic hit_reload, hit_ctrl, hit_clear, hit_lock;
   logic [BUS_W-1:0] rd_mux;

   assign wr_open    = wr_en && !locked;
   assign hit_lock   = wr_en && (addr == A_LOCK);
   assign hit_reload = wr_open && (addr == A_RELOAD);
   assign hit_ctrl   = wr_open && (addr == A_CTRL);
   assign hit_clear  = wr_open && (addr == A_CLEAR);

   assign clr_req    = hit_clear && wdata[0];
   assign reload_req = clr_req || (hit_ctrl && wdata[CTRL_RUN_BIT] && !ctrl.run);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked     <= 1'b1;
         ctrl       <= '0;
         reload_val <= LOAD_INIT;
      end else begin
         if (hit_lock)   locked     <= (wdata != KEY);
         if (hit_reload) reload_val <= wdata[CNT_W-1:0];
         if (hit_ctrl) begin
            ctrl.run    <= wdata[CTRL_RUN_BIT];
            ctrl.rst_en <= wdata[CTRL_RST_BIT];
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      unique case (addr)
         A_RELOAD: rd_mux = BUS_W'(reload_val);
         A_COUNT:  rd_mux = BUS_W'(cnt);
         A_CTRL:   rd_mux = BUS_W'(ctrl);
         A_STAT:   rd_mux = BUS_W'(irq_pend);
         A_LOCK:   rd_mux = BUS_W'(locked);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
   parameter int unsigned      CNT_W     = 32,
   parameter logic [CNT_W-1:0] LOAD_INIT = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             reload_req,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expire
);
   assign expire = run && !reload_req && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= LOAD_INIT;
      else if (reload_req) cnt <= reload_val;
      else if (expire)     cnt <= reload_val;
      else if (run)        cnt <= cnt - 1'b1;
   end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage #(
   parameter bit RST_STICKY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic clr_req,
   input  logic rst_en,
   output logic irq_pend,
   output logic sys_rst
);
   logic second_hit;

   assign second_hit = expire && irq_pend && rst_en;

   always_ff @(posedge clk) begin
      if (!rst_n)       irq_pend <= 1'b0;
      else if (clr_req) irq_pend <= 1'b0;
      else if (expire)  irq_pend <= 1'b1;
   end

   generate
      if (RST_STICKY) begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)          sys_rst <= 1'b0;
            else if (second_hit) sys_rst <= 1'b1;
         end
      end else begin : g_pulse
         always_ff @(posedge clk) begin
            if (!rst_n) sys_rst <= 1'b0;
            else        sys_rst <= second_hit;
         end
      end
   endgenerate
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
   import wdog_pkg::*;
#(
   parameter int unsigned          CNT_W      = 32,
   parameter logic [BUS_W-1:0]     KEY        = 32'h1ACC_E551,
   parameter logic [CNT_W-1:0]     LOAD_INIT  = '1,
   parameter bit                   RST_STICKY = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [11:0] addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        irq,
   output logic        sys_rst
);
   generate
      if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_width
         $error("wdog_two_stage: CNT_W must lie in 2..32");
      end
   endgenerate

   logic             locked;
   ctrl_t            ctrl_q;
   logic             run, rst_en;
   logic [CNT_W-1:0] reload_val, cnt_q;
   logic             reload_req, clr_req, expire;

   assign run    = ctrl_q.run;
   assign rst_en = ctrl_q.rst_en;

   wdog_regfile #(.CNT_W(CNT_W), .KEY(KEY), .LOAD_INIT(LOAD_INIT)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .cnt(cnt_q), .irq_pend(irq), .rdata(rdata),
      .locked(locked), .ctrl(ctrl_q), .reload_val(reload_val),
      .reload_req(reload_req), .clr_req(clr_req)
   );

   wdog_downcnt #(.CNT_W(CNT_W), .LOAD_INIT(LOAD_INIT)) i_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .reload_req(reload_req),
      .reload_val(reload_val), .cnt(cnt_q), .expire(expire)
   );

   wdog_stage #(.RST_STICKY(RST_STICKY)) i_stage (
      .clk(clk), .rst_n(rst_n), .expire(expire), .clr_req(clr_req),
      .rst_en(rst_en), .irq_pend(irq), .sys_rst(sys_rst)
   );
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W      = 32,
   parameter bit          RST_STICKY = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic              locked,
   input logic              run,
   input logic              rst_en,
   input logic              reload_req,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  reload_val,
   input logic              irq,
   input logic              sys_rst
);
   // R2
   locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && wr_en && addr != A_LOCK) |=>
         ($stable(reload_val) && $stable(run) && $stable(rst_en)));

   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !reload_req && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   // R4
   irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(run && cnt == '0));

   // R9
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !reload_req) |=> $stable(cnt));

   // R5
   rst_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> ($past(irq) && $past(rst_en)));

   generate
      if (RST_STICKY) begin : g_hold_chk
         // R10
         rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sys_rst |=> sys_rst);
      end
   endgenerate
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CNT_W(CNT_W), .RST_STICKY(RST_STICKY)) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .locked(locked),
   .run(run), .rst_en(rst_en), .reload_req(reload_req), .cnt(cnt_q),
   .reload_val(reload_val), .irq(irq), .sys_rst(sys_rst)
);

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;
   import wdog_pkg::*;

   localparam logic [31:0] KEY = 32'h1ACC_E551;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata_a, rdata_b;
   logic        irq_a, irq_b, srst_a, srst_b;
   int          n_chk = 0, n_fail = 0;
   logic [31:0] ra, rb;

   always #2 clk = ~clk;

   wdog_two_stage #(.RST_STICKY(1'b1)) i_wdog_two_stage (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata_a), .irq(irq_a), .sys_rst(srst_a));

   wdog_two_stage #(.RST_STICKY(1'b0)) i_wdog_two_stage_pulse (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata_b), .irq(irq_b), .sys_rst(srst_b));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [11:0] a, output logic [31:0] da, output logic [31:0] db);
      rd_en = 1'b1; addr = a;
      @(posedge clk);
      @(negedge clk);
      da = rdata_a; db = rdata_b;
      rd_en = 1'b0;
   endtask

   task automatic wait_rise(input bit use_rst, input int limit, inout int cyc);
      while (((use_rst ? srst_a : irq_a) == 1'b0) && cyc < limit) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R11 reset state
      do_reset();
      check("R11 irq", 32'(irq_a), 0);
      check("R11 sys_rst", 32'(srst_a | srst_b), 0);
      bus_rd(A_CTRL, ra, rb);   check("R11 ctrl", ra, 0);
      bus_rd(A_RELOAD, ra, rb); check("R11 reload", ra, 32'hFFFF_FFFF);
      bus_rd(A_COUNT, ra, rb);  check("R11 count", ra, 32'hFFFF_FFFF);
      bus_rd(A_STAT, ra, rb);   check("R11 status", ra, 0);
      bus_rd(A_LOCK, ra, rb);   check("R1 locked after reset", ra, 1);

      // R2 locked writes dropped
      bus_wr(A_RELOAD, 5);
      bus_wr(A_CTRL, 3);
      bus_rd(A_RELOAD, ra, rb); check("R2 reload kept", ra, 32'hFFFF_FFFF);
      bus_rd(A_CTRL, ra, rb);   check("R2 ctrl kept", ra, 0);

      // R1 key handling, R3 reserved bits
      bus_wr(A_LOCK, KEY ^ 32'h1);
      bus_rd(A_LOCK, ra, rb);   check("R1 wrong key stays locked", ra, 1);
      bus_wr(A_LOCK, KEY);
      bus_rd(A_LOCK, ra, rb);   check("R1 key unlocks", ra, 0);
      bus_wr(A_CTRL, 32'hFFFF_FFFE);
      bus_rd(A_CTRL, ra, rb);   check("R3 reserved read zero", ra, 2);
      bus_wr(A_LOCK, 32'h0);
      bus_rd(A_LOCK, ra, rb);   check("R1 relock", ra, 1);
      bus_wr(A_CTRL, 0);
      bus_rd(A_CTRL, ra, rb);   check("R2 ctrl write after relock dropped", ra, 2);

      // R4 R5 R10 sweep over reload values and reset enable
      for (int n = 0; n <= 5; n++) begin
         for (int re = 0; re <= 1; re++) begin
            int cyc;
            do_reset();
            bus_wr(A_LOCK, KEY);
            bus_wr(A_RELOAD, n);
            bus_wr(A_CTRL, re ? 3 : 1);
            cyc = 0;
            wait_rise(1'b0, 200, cyc);
            check("R4 first expiry cycle", cyc, n + 1);
            check("R4 pulse instance irq", 32'(irq_b), 1);
            check("R5 no reset at first expiry", 32'(srst_a | srst_b), 0);
            wait_rise(1'b1, 4 * n + 12, cyc);
            if (re == 1) begin
               check("R5 reset cycle", cyc, 2 * n + 2);
               check("R10 pulse instance high", 32'(srst_b), 1);
               @(negedge clk);
               check("R10 sticky holds", 32'(srst_a), 1);
               if (n > 0) check("R10 pulse one cycle", 32'(srst_b), 0);
            end else begin
               check("R5 no reset without enable", 32'(srst_a | srst_b), 0);
            end
         end
      end

      // R8 live count, R9 freeze, R4 reload on enable
      do_reset();
      bus_wr(A_LOCK, KEY);
      bus_wr(A_RELOAD, 20);
      bus_wr(A_CTRL, 1);
      for (int j = 0; j < 4; j++) begin
         bus_rd(A_COUNT, ra, rb);
         check("R8 live count", ra, 20 - j);
      end
      bus_wr(A_CTRL, 0);
      bus_rd(A_COUNT, ra, rb);  check("R9 frozen count", ra, 15);
      repeat (5) @(negedge clk);
      bus_rd(A_COUNT, ra, rb);  check("R9 still frozen", ra, 15);
      bus_wr(A_CTRL, 1);
      bus_rd(A_COUNT, ra, rb);  check("R4 enable reloads", ra, 20);
      bus_rd(A_COUNT, ra, rb);  check("R8 next count", ra, 19);

      // R6 R7 clear behaviour
      begin
         int cyc;
         do_reset();
         bus_wr(A_LOCK, KEY);
         bus_wr(A_RELOAD, 5);
         bus_wr(A_CTRL, 3);
         cyc = 0;
         wait_rise(1'b0, 50, cyc);
         bus_rd(A_STAT, ra, rb);  check("R7 status pending", ra, 1);
         bus_wr(A_CLEAR, 32'hFFFF_FFFE);
         check("R6 clear bit0=0 no effect", 32'(irq_a), 1);
         bus_wr(A_CLEAR, 1);
         check("R6 clear drops irq", 32'(irq_a), 0);
         bus_rd(A_STAT, ra, rb);  check("R7 status cleared", ra, 0);
         cyc = 1;
         wait_rise(1'b0, 50, cyc);
         check("R6 clear reloads counter", cyc, 6);
         check("R6 no reset after clear", 32'(srst_a), 0);

         // R9 pending irq kept while stopped, no reset
         bus_wr(A_CTRL, 2);
         repeat (20) @(negedge clk);
         check("R9 irq kept while stopped", 32'(irq_a), 1);
         check("R9 no reset while stopped", 32'(srst_a | srst_b), 0);

         // R6 clear on the expiry edge wins
         do_reset();
         bus_wr(A_LOCK, KEY);
         bus_wr(A_RELOAD, 3);
         bus_wr(A_CTRL, 3);
         repeat (3) @(negedge clk);
         bus_wr(A_CLEAR, 1);
         check("R6 clear beats expiry", 32'(irq_a), 0);
         cyc = 0;
         wait_rise(1'b0, 50, cyc);
         check("R6 period after race", cyc, 4);
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule